// File: doc/BRIEF.md
# Multi-Bank Row ECC Checker

This block guards a memory whose rows hold several banks side by side, each bank storing its own data word together with a few check bits. On every read strobe it decodes the whole addressed row, bank by bank. This happens even though the reader asks for only one bank. It returns the requested bank's data and a row-level verdict: clean, corrected, or non-corrected. A companion encoder computes the check bits for a word about to be written, so writes and reads use one parity layout.

Two decode modes are selected by an input. In the correcting mode the stored word is an extended Hamming codeword: a single flipped bit is repaired and reported as corrected, and two flipped bits are reported as non-corrected. In the detect-only mode only the plain Hamming part is checked: any nonzero syndrome is non-corrected and the data is passed on untouched. Stored words that are entirely zeros or entirely ones are always treated as non-corrected, before any syndrome decoding. A global enable input suppresses all reporting.

Top module: `mbecc_row_checker`

## Requirements
- R1: `wr_chk` equals `{P, H}` where H[i] is the XOR of every data bit whose codeword position has bit i set, and P is the XOR of all data bits and H. Data bit j sits at the j-th position, counting upward from 1, that is not a power of two. A row written with these check bits reads back with `st_ok` high and `err_syn` zero.
- R2: In correcting mode (`secded_mode`=1), a bank with exactly one flipped bit among data and check bits is classed as corrected. If the requested bank is such a bank, `rd_data` is its original data.
- R3: In correcting mode, a bank with exactly two flipped bits is classed as non-corrected.
- R4: In detect-only mode (`secded_mode`=0), a bank with a nonzero Hamming syndrome is non-corrected, the overall parity bit (check bit CHK_W-1) is ignored, `rd_data` is always the raw stored data and `st_corr` never rises.
- R5: A bank whose data and check bits are all zeros is non-corrected in both modes.
- R6: A bank whose data and check bits are all ones is non-corrected in both modes.
- R7: Every bank of the row is decoded on each read. The row status is the most severe bank class (non-corrected over corrected over clean), even when the requested bank is clean.
- R8: A read strobe sampled at a rising edge yields `rd_valid` high for exactly the following cycle, with results registered at that same edge. Without a strobe, `rd_valid` is low and all other outputs hold. After reset `rd_valid` is 0 and `st_ok` is 1.
- R9: While `ecc_en` is low at the strobe, the result shows `st_ok`=1, `err_bank`=0 and `err_syn`=0, and `rd_data` follows the same rules as when enabled.
- R10: `err_bank` is the lowest-indexed bank not classed clean, and `err_syn` is that bank's `{overall parity mismatch, Hamming syndrome}`. Both are zero when all banks are clean.
- R11: Three or more flipped bits are classified purely by the syndrome rules: correcting mode gives corrected when the overall parity is odd and the syndrome is at most DATA_W+HAM_W, non-corrected otherwise when nonzero. Detect-only mode gives non-corrected for a nonzero Hamming syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en | input | 1 | Enables error reporting |
| secded_mode | input | 1 | 1: correcting mode, 0: detect-only |
| rd_stb | input | 1 | Read strobe |
| rd_bank | input | IDX_W | Requested bank index |
| row_data | input | NUM_BANKS*DATA_W | Stored data of all banks, bank b at bits b*DATA_W upward |
| row_chk | input | NUM_BANKS*CHK_W | Stored check bits of all banks |
| wr_data | input | DATA_W | Word to encode for writing |
| wr_chk | output | CHK_W | Check bits for `wr_data` |
| rd_valid | output | 1 | Result valid pulse |
| rd_data | output | DATA_W | Requested bank data, corrected where allowed |
| st_ok | output | 1 | Row clean |
| st_corr | output | 1 | Row has a corrected error |
| st_uncorr | output | 1 | Row has a non-corrected error |
| err_bank | output | IDX_W | First failing bank |
| err_syn | output | CHK_W | Syndrome of the first failing bank |

## Verification
The bench builds the block with its defaults: four banks of 16-bit data, five Hamming bits plus one parity bit. That makes a 22-bit codeword whose every bit can be flipped in turn in both modes, and the 5-bit syndrome can land beyond position 21, so triple flips reach the out-of-range non-corrected case. Four banks leave room to place clean, corrected and non-corrected banks in one row, which exercises the severity merge and the lowest-failing-bank choice.

// File: rtl/mbecc_pkg.sv
package mbecc_pkg;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_CORR   = 2'd1,
        CLS_UNCORR = 2'd2
    } ecc_class_e;

    // Number of Hamming check bits for a data width.
    function automatic int ham_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // Codeword position (1-based) of data bit j: the j-th non power of two.
    function automatic int data_pos(input int j, input int dw);
        int hw;
        int cnt;
        hw  = ham_bits(dw);
        cnt = 0;
        for (int q = 1; q <= dw + hw; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (cnt == j) return q;
                cnt++;
            end
        end
        return 0;
    endfunction

    // Data bits covered by Hamming check bit i (data widths up to 256).
    function automatic logic [255:0] col_mask(input int i, input int dw);
        logic [255:0] m;
        m = '0;
        for (int j = 0; j < dw; j++) begin
            if (((data_pos(j, dw) >> i) & 1) == 1) m[j] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mbecc_encoder.sv
module mbecc_encoder
    import mbecc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HAM_W  = 5
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [HAM_W-1:0]  ham_o
);

    for (genvar gi = 0; gi < HAM_W; gi++) begin : g_col
        localparam logic [255:0] MASK = col_mask(gi, DATA_W);
        assign ham_o[gi] = ^(data_i & MASK[DATA_W-1:0]);
    end

endmodule

// File: rtl/mbecc_bank_dec.sv
module mbecc_bank_dec
    import mbecc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HAM_W  = 5,
    parameter int CHK_W  = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    input  logic              secded_i,
    output ecc_class_e        cls_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  syn_o
);

    localparam int NPOS = DATA_W + HAM_W;

    logic [HAM_W-1:0]  ham_re;
    logic [HAM_W-1:0]  syn;
    logic              par_odd;
    logic [DATA_W-1:0] flip;
    logic              special;

    mbecc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) enc_i (
        .data_i (data_i),
        .ham_o  (ham_re)
    );

    for (genvar gj = 0; gj < DATA_W; gj++) begin : g_flip
        localparam int PJ = data_pos(gj, DATA_W);
        assign flip[gj] = (syn == HAM_W'(PJ));
    end

    always_comb begin
        syn     = ham_re ^ chk_i[HAM_W-1:0];
        par_odd = ^{data_i, chk_i};
        special = ({data_i, chk_i} == '0) || (&{data_i, chk_i});
        cls_o   = CLS_NONE;
        data_o  = data_i;
        if (special) begin
            cls_o = CLS_UNCORR;
        end else if (secded_i) begin
            if (par_odd) begin
                if (int'(syn) <= NPOS) begin
                    cls_o  = CLS_CORR;
                    data_o = data_i ^ flip;
                end else begin
                    cls_o = CLS_UNCORR;
                end
            end else if (syn != '0) begin
                cls_o = CLS_UNCORR;
            end
        end else if (syn != '0) begin
            cls_o = CLS_UNCORR;
        end
        syn_o = {par_odd, syn};
    end

    // R4: detect-only never alters data and never reports a correction
    always_comb begin
        if (!secded_i) begin
            p_detect_raw_r4: assert (data_o == data_i && cls_o != CLS_CORR);
        end
    end

    // R5: an all-zero stored word is always non-corrected
    always_comb begin
        if ({data_i, chk_i} == '0) begin
            p_zero_word_r5: assert (cls_o == CLS_UNCORR);
        end
    end

endmodule

// File: rtl/mbecc_row_checker.sv
module mbecc_row_checker
    import mbecc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4,
    localparam int HAM_W    = ham_bits(DATA_W),
    localparam int CHK_W    = HAM_W + 1,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ecc_en,
    input  logic                        secded_mode,
    input  logic                        rd_stb,
    input  logic [IDX_W-1:0]            rd_bank,
    input  logic [NUM_BANKS*DATA_W-1:0] row_data,
    input  logic [NUM_BANKS*CHK_W-1:0]  row_chk,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [CHK_W-1:0]            wr_chk,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        st_ok,
    output logic                        st_corr,
    output logic                        st_uncorr,
    output logic [IDX_W-1:0]            err_bank,
    output logic [CHK_W-1:0]            err_syn
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        ecc_class_e        cls;
        logic [IDX_W-1:0]  bank;
        logic [CHK_W-1:0]  syn;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    ecc_class_e        cls_b [NUM_BANKS];
    logic [DATA_W-1:0] dat_b [NUM_BANKS];
    logic [CHK_W-1:0]  syn_b [NUM_BANKS];
    logic [HAM_W-1:0]  wr_ham;

    // Write-side encoder shares the parity layout of the decoders.
    mbecc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) wr_enc_i (
        .data_i (wr_data),
        .ham_o  (wr_ham)
    );
    assign wr_chk = {^{wr_data, wr_ham}, wr_ham};

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        mbecc_bank_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W)) dec_i (
            .data_i   (row_data[gb*DATA_W +: DATA_W]),
            .chk_i    (row_chk[gb*CHK_W +: CHK_W]),
            .secded_i (secded_mode),
            .cls_o    (cls_b[gb]),
            .data_o   (dat_b[gb]),
            .syn_o    (syn_b[gb])
        );
    end

    always_comb begin
        ecc_class_e       worst;
        logic             found;
        logic [IDX_W-1:0] fbank;
        logic [CHK_W-1:0] fsyn;
        worst = CLS_NONE;
        found = 1'b0;
        fbank = '0;
        fsyn  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (cls_b[b] != CLS_NONE) begin
                if (!found) begin
                    found = 1'b1;
                    fbank = IDX_W'(b);
                    fsyn  = syn_b[b];
                end
                if (cls_b[b] == CLS_UNCORR) worst = CLS_UNCORR;
                else if (worst == CLS_NONE) worst = CLS_CORR;
            end
        end
        rd_d       = rd_q;
        rd_d.valid = 1'b0;
        if (rd_stb) begin
            rd_d.valid = 1'b1;
            rd_d.data  = dat_b[rd_bank];
            if (ecc_en) begin
                rd_d.cls  = worst;
                rd_d.bank = fbank;
                rd_d.syn  = fsyn;
            end else begin
                rd_d.cls  = CLS_NONE;
                rd_d.bank = '0;
                rd_d.syn  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid  = rd_q.valid;
    assign rd_data   = rd_q.data;
    assign st_ok     = (rd_q.cls == CLS_NONE);
    assign st_corr   = (rd_q.cls == CLS_CORR);
    assign st_uncorr = (rd_q.cls == CLS_UNCORR);
    assign err_bank  = rd_q.bank;
    assign err_syn   = rd_q.syn;

    // R8: one valid cycle per strobe, none without
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!rd_valid && $stable(rd_data) && $stable(err_syn)));

    // R9: disabled reporting leaves only the clean verdict
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(ecc_en)) |-> (st_ok && err_bank == '0 && err_syn == '0));

    // R10: a clean row carries no diagnostics
    p_clean_diag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && st_ok) |-> (err_bank == '0 && err_syn == '0));

    // R4: detect-only reads never report a correction
    p_detect_no_corr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(secded_mode)) |-> !st_corr);

endmodule

// File: tb/mbecc_row_checker_tb_top.sv
module mbecc_row_checker_tb_top;

    localparam int DW = 16;
    localparam int NB = 4;
    localparam int HW = 5;
    localparam int CW = HW + 1;
    localparam int NP = DW + HW;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ecc_en = 1'b1;
    logic              secded_mode = 1'b1;
    logic              rd_stb = 1'b0;
    logic [IW-1:0]     rd_bank = '0;
    logic [DW-1:0]     bd [NB];
    logic [CW-1:0]     bc [NB];
    logic [NB*DW-1:0]  row_data;
    logic [NB*CW-1:0]  row_chk;
    logic [DW-1:0]     wr_data = '0;
    logic [CW-1:0]     wr_chk;
    logic              rd_valid, st_ok, st_corr, st_uncorr;
    logic [DW-1:0]     rd_data;
    logic [IW-1:0]     err_bank;
    logic [CW-1:0]     err_syn;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            row_data[b*DW +: DW] = bd[b];
            row_chk[b*CW +: CW]  = bc[b];
        end
    end

    mbecc_row_checker #(.DATA_W(DW), .NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .secded_mode(secded_mode),
        .rd_stb(rd_stb), .rd_bank(rd_bank), .row_data(row_data), .row_chk(row_chk),
        .wr_data(wr_data), .wr_chk(wr_chk), .rd_valid(rd_valid), .rd_data(rd_data),
        .st_ok(st_ok), .st_corr(st_corr), .st_uncorr(st_uncorr),
        .err_bank(err_bank), .err_syn(err_syn)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] m_encode(input logic [DW-1:0] d);
        logic [NP:1]   cw;
        logic [HW-1:0] h;
        int j;
        cw = '0; j = 0;
        for (int p = 1; p <= NP; p++)
            if ((p & (p - 1)) != 0) begin cw[p] = d[j]; j++; end
        h = '0;
        for (int i = 0; i < HW; i++)
            for (int p = 1; p <= NP; p++)
                if (((p >> i) & 1) == 1 && (p & (p - 1)) != 0) h[i] = h[i] ^ cw[p];
        return {^{d, h}, h};
    endfunction

    task automatic m_decode(input logic [DW-1:0] d, input logic [CW-1:0] c, input bit sec,
                            output int cls, output logic [DW-1:0] dout, output logic [CW-1:0] sy);
        logic [NP:1] cw;
        int s, j;
        logic ov;
        cw = '0; j = 0;
        for (int p = 1; p <= NP; p++)
            if ((p & (p - 1)) != 0) begin cw[p] = d[j]; j++; end
        for (int i = 0; i < HW; i++) cw[1 << i] = c[i];
        s = 0;
        for (int p = 1; p <= NP; p++) if (cw[p]) s = s ^ p;
        ov = ^{d, c};
        dout = d; cls = 0;
        if ({d, c} == '0 || (&{d, c})) cls = 2;
        else if (sec) begin
            if (ov) begin
                if (s <= NP) begin
                    cls = 1;
                    if (s != 0 && (s & (s - 1)) != 0) begin
                        j = 0;
                        for (int p = 1; p < s; p++) if ((p & (p - 1)) != 0) j++;
                        dout[j] = ~dout[j];
                    end
                end else cls = 2;
            end else if (s != 0) cls = 2;
        end else if (s != 0) cls = 2;
        sy = {ov, s[HW-1:0]};
    endtask

    // Compare registered outputs of one read against the model.
    task automatic do_read(input string req, input int bank);
        int cls, worst, fb;
        logic [DW-1:0] dd, exp_d;
        logic [CW-1:0] sy, fs;
        @(negedge clk);
        rd_bank = IW'(bank);
        rd_stb  = 1'b1;
        @(negedge clk);
        rd_stb  = 1'b0;
        worst = 0; fb = -1; fs = '0; exp_d = '0;
        for (int b = 0; b < NB; b++) begin
            m_decode(bd[b], bc[b], secded_mode, cls, dd, sy);
            if (b == bank) exp_d = dd;
            if (cls != 0 && fb < 0) begin fb = b; fs = sy; end
            if (cls > worst) worst = cls;
        end
        if (!ecc_en) begin worst = 0; fb = -1; fs = '0; end
        if (fb < 0) fb = 0;
        check({req, " valid"}, 64'(rd_valid), 64'(1));
        check({req, " data"}, 64'(rd_data), 64'(exp_d));
        check({req, " ok"}, 64'(st_ok), 64'(worst == 0));
        check({req, " corr"}, 64'(st_corr), 64'(worst == 1));
        check({req, " uncorr"}, 64'(st_uncorr), 64'(worst == 2));
        check({req, " err_bank R10"}, 64'(err_bank), 64'(fb));
        check({req, " err_syn R10"}, 64'(err_syn), 64'(fs));
    endtask

    task automatic fill_clean();
        for (int b = 0; b < NB; b++) begin
            bd[b] = DW'($urandom);
            bc[b] = m_encode(bd[b]);
        end
    endtask

    task automatic flip_bit(input int b, input int k);
        logic [DW+CW-1:0] w;
        w = {bc[b], bd[b]};
        w[k] = ~w[k];
        {bc[b], bd[b]} = w;
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] keep;
        void'($urandom(32'h1d5e_0a73));
        fill_clean();
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset valid", 64'(rd_valid), 64'(0));
        check("R8 reset ok", 64'(st_ok), 64'(1));
        check("R8 reset uncorr", 64'(st_uncorr), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R1: encoder against model, then clean readback
        for (int n = 0; n < 40; n++) begin
            wr_data = DW'($urandom);
            #1;
            check("R1 encoder", 64'(wr_chk), 64'(m_encode(wr_data)));
        end
        for (int b = 0; b < NB; b++) begin
            wr_data = DW'($urandom); #1;
            bd[b] = wr_data; bc[b] = wr_chk;
        end
        do_read("R1 clean readback", 1);
        check("R1 clean syn", 64'(err_syn), 64'(0));

        // R2 / R4: every single-bit position of bank 2, both modes
        for (int k = 0; k < DW + CW; k++) begin
            fill_clean();
            keep = bd[2];
            flip_bit(2, k);
            secded_mode = 1'b1;
            do_read("R2 single flip", 2);
            check("R2 corrected", 64'(st_corr), 64'(1));
            check("R2 restored", 64'(rd_data), 64'(keep));
            secded_mode = 1'b0;
            do_read("R4 detect single", 2);
            check("R4 detect verdict", 64'(st_uncorr), 64'(k != DW + CW - 1));
        end
        secded_mode = 1'b1;

        // R3: double flips
        for (int n = 0; n < 30; n++) begin
            int k1, k2;
            fill_clean();
            k1 = $urandom % (DW + CW);
            k2 = (k1 + 1 + $urandom % (DW + CW - 1)) % (DW + CW);
            flip_bit(0, k1); flip_bit(0, k2);
            do_read("R3 double flip", 0);
            check("R3 uncorr", 64'(st_uncorr), 64'(1));
        end

        // R5 / R6: special words in both modes
        for (int m = 0; m < 2; m++) begin
            secded_mode = m[0];
            fill_clean();
            bd[1] = '0; bc[1] = '0;
            do_read("R5 all zeros", 1);
            check("R5 uncorr", 64'(st_uncorr), 64'(1));
            fill_clean();
            bd[3] = '1; bc[3] = '1;
            do_read("R6 all ones", 3);
            check("R6 uncorr", 64'(st_uncorr), 64'(1));
        end
        secded_mode = 1'b1;

        // R7 / R10: severity merge with a clean requested bank
        fill_clean();
        keep = bd[1];
        flip_bit(0, 5);
        flip_bit(3, 2); flip_bit(3, 11);
        do_read("R7 merge", 1);
        check("R7 worst wins", 64'(st_uncorr), 64'(1));
        check("R7 clean bank data", 64'(rd_data), 64'(keep));
        check("R10 first bank", 64'(err_bank), 64'(0));
        fill_clean();
        flip_bit(2, 7);
        do_read("R7 corrected only", 0);
        check("R7 corr flag", 64'(st_corr), 64'(1));

        // R9: reporting disabled, correction still applied
        ecc_en = 1'b0;
        fill_clean();
        keep = bd[2];
        flip_bit(2, 3); flip_bit(1, 0); flip_bit(1, 9);
        do_read("R9 disabled", 2);
        check("R9 ok", 64'(st_ok), 64'(1));
        check("R9 data", 64'(rd_data), 64'(keep));
        ecc_en = 1'b1;

        // R8: valid is a single-cycle pulse, outputs hold
        keep = rd_data;
        @(negedge clk);
        check("R8 valid drop", 64'(rd_valid), 64'(0));
        check("R8 data hold", 64'(rd_data), 64'(keep));

        // R11: triple flips decided by syndrome rules
        for (int n = 0; n < 60; n++) begin
            fill_clean();
            secded_mode = n[0];
            for (int f = 0; f < 3; f++) flip_bit(n % NB, (n * 7 + f * 5) % (DW + CW));
            do_read("R11 triple flip", n % NB);
        end

        // Random mix across all requirements
        for (int n = 0; n < 400; n++) begin
            fill_clean();
            for (int b = 0; b < NB; b++) begin
                int r;
                r = $urandom % 16;
                if (r == 0) begin bd[b] = '0; bc[b] = '0; end
                else if (r == 1) begin bd[b] = '1; bc[b] = '1; end
                else for (int f = 0; f < (r % 4); f++) flip_bit(b, $urandom % (DW + CW));
            end
            secded_mode = 1'($urandom);
            ecc_en      = ($urandom % 8) != 0;
            do_read("R7 random", $urandom % NB);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule